// File: doc/BRIEF.md
# Memory Controller Event Counter Unit

This unit watches a memory controller and counts what it does. The controller sends one-cycle pulses for four kinds of event: read, write, row activate and idle. Each event kind has its own counter. A fifth counter counts clock cycles, so software can turn event counts into rates. Software reaches all state through a plain register bus. The bus has an address, a write enable and write data, and its read data follows the address combinationally.

Software starts and stops all counting with one control register. It enables each event counter separately, and it can clear any mix of counters with a single write. If any counter rolls over from all ones to zero, counting stops for every counter at once, so the counts stay consistent with each other. The rollover also leaves a sticky flag and can raise an interrupt line. To resume, software clears the counter that rolled over and writes start again.

Top module: `mc_evt_monitor`

## Requirements
- R1: After synchronous reset, all counters, the run bit, the enable mask, the overflow flags, the interrupt enables and the interrupt flags are zero, and `irq` is low.
- R2: Writing the control register (offset 0x000) with bit 0 set and bit 1 clear starts counting. Writing it with bit 1 set stops counting; stop wins when both bits are set. Bit 0 of the control register reads 1 while counting runs. While counting is stopped, every counter holds its value whatever pulses arrive.
- R3: Event counters use index 0 for read, 1 for write, 2 for activate and 3 for idle. Event counter X is read at offset 0x030 + 8*X. While counting runs, it rises by one at each clock edge where its pulse is high, but only if bit X of the enable register (offset 0x004) is set. Otherwise it holds its value.
- R4: The cycle counter is read at offset 0x020. It rises by one at every clock edge while counting runs, whatever the enable register holds.
- R5: The clear register is at offset 0x00C. Writing 1 to bit X zeroes event counter X and its overflow flag; bit 31 does the same for the cycle counter. Counters whose bits are 0 keep their values, so writing 0x8000000F zeroes all five.
- R6: If a counter is cleared and would have incremented at the same clock edge, the clear wins and the counter reads 0 afterwards.
- R7: A counter that increments from all ones wraps to 0 and sets its sticky flag in the overflow status register (offset 0x008, bit X for event counter X, bit 31 for the cycle counter). Counters that increment at that same edge still count. After that edge, counting is stopped for all counters and control bit 0 reads 0.
- R8: After an overflow has stopped counting, a start write makes counters count again from the clock edge that follows the write.
- R9: An overflow also sets the matching bit of the interrupt flag register (offset 0x014, same bit layout as R7). `irq` is high when any flag bit is set together with the same bit of the interrupt enable register (offset 0x010). Writing 1 to a bit of the interrupt clear register (offset 0x018) clears that flag bit.
- R10: The fixed registers read as follows: 0x3FC reads 0xA3C5DD01, 0x3F8 reads the ID parameter, 0x3F4 reads the version parameter, and 0x3F0 reads the counter width in bits 15:8 and the number of event counters in bits 7:0. Writes to these registers have no effect.
- R11: Reads from any offset not named above return 0, and so do reads of the write-only clear registers at 0x00C and 0x018.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_EVT | One-cycle event pulses, bit X for event counter X |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 10 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest state to reach is the overflow freeze: a counter has to pass through every value of its width before it wraps. The bench therefore builds the unit with 6-bit counters, so the cycle counter wraps after 64 running cycles while the read counter lags a few counts behind. A second run, started after clearing only the cycle counter, then drives the read counter through its own wrap. The interrupt mask is set so the first overflow is masked and the second is not. A sweep over all sixteen enable masks covers how the enable bits combine with the event pulses.

// File: rtl/mc_evt_pkg.sv
`timescale 1ns/1ps
package mc_evt_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 10;
    localparam int TIME_BIT = 31;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_CFG   = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 10'h008;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 10'h00C;
    localparam logic [ADDR_W-1:0] OFS_IER   = 10'h010;
    localparam logic [ADDR_W-1:0] OFS_ISR   = 10'h014;
    localparam logic [ADDR_W-1:0] OFS_ICR   = 10'h018;
    localparam logic [ADDR_W-1:0] OFS_TIME  = 10'h020;
    localparam logic [ADDR_W-1:0] OFS_EVT0  = 10'h030;
    localparam logic [ADDR_W-1:0] OFS_HWCFG = 10'h3F0;
    localparam logic [ADDR_W-1:0] OFS_VER   = 10'h3F4;
    localparam logic [ADDR_W-1:0] OFS_IDR   = 10'h3F8;
    localparam logic [ADDR_W-1:0] OFS_SIG   = 10'h3FC;

    localparam logic [REG_W-1:0] SIG_VALUE = 32'hA3C5_DD01;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_STOP_BIT  = 1;

    typedef enum logic [1:0] {
        EV_READ  = 2'd0,
        EV_WRITE = 2'd1,
        EV_ACT   = 2'd2,
        EV_IDLE  = 2'd3
    } evt_kind_e;

    typedef struct packed {
        logic              ctrl;
        logic              cfg;
        logic              clr;
        logic              ier;
        logic              icr;
    } wr_sel_t;

    function automatic logic [ADDR_W-1:0] evt_ofs(input int unsigned idx);
        return ADDR_W'(32'(OFS_EVT0) + 8 * idx);
    endfunction

endpackage

// File: rtl/mc_evt_ctr.sv
`timescale 1ns/1ps
module mc_evt_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] value,
    output logic             wrap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end

    assign wrap = inc & ~clr & (&value);

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(value)); // R2

    AST_CLEAR_BEATS_INC: assert property (@(posedge clk) disable iff (rst)
        (clr && inc) |=> (value == '0)); // R6

endmodule

// File: rtl/mc_evt_bank.sv
`timescale 1ns/1ps
module mc_evt_bank #(
    parameter int NUM_CTR = 5,
    parameter int CNT_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CTR-1:0]       inc,
    input  logic [NUM_CTR-1:0]       clr,
    output logic [NUM_CTR*CNT_W-1:0] vals,
    output logic [NUM_CTR-1:0]       ovf,
    output logic [NUM_CTR-1:0]       wrap
);

    logic [NUM_CTR-1:0] ovf_q;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        mc_evt_ctr #(.CNT_W(CNT_W)) ctr_i (
            .clk   (clk),
            .rst   (rst),
            .inc   (inc[g]),
            .clr   (clr[g]),
            .value (vals[g*CNT_W +: CNT_W]),
            .wrap  (wrap[g])
        );

        AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
            wrap[g] |=> ovf_q[g]); // R7
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= '0;
        end else begin
            ovf_q <= (ovf_q & ~clr) | wrap;
        end
    end

    assign ovf = ovf_q;

endmodule

// File: rtl/mc_evt_irq.sv
`timescale 1ns/1ps
module mc_evt_irq #(
    parameter int NUM_CTR = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTR-1:0] set,
    input  logic               ier_we,
    input  logic               icr_we,
    input  logic [NUM_CTR-1:0] wbits,
    output logic [NUM_CTR-1:0] ier,
    output logic [NUM_CTR-1:0] isr,
    output logic               irq
);

    logic [NUM_CTR-1:0] ier_q;
    logic [NUM_CTR-1:0] isr_q;
    logic [NUM_CTR-1:0] isr_clr;

    assign isr_clr = icr_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q <= '0;
            isr_q <= '0;
        end else begin
            if (ier_we) begin
                ier_q <= wbits;
            end
            isr_q <= (isr_q & ~isr_clr) | set;
        end
    end

    assign ier = ier_q;
    assign isr = isr_q;
    assign irq = |(isr_q & ier_q);

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !icr_we |=> ((isr_q & $past(isr_q)) == $past(isr_q))); // R9

endmodule

// File: rtl/mc_evt_monitor.sv
`timescale 1ns/1ps
module mc_evt_monitor
    import mc_evt_pkg::*;
#(
    parameter int          NUM_EVT = 4,
    parameter int          CNT_W   = 32,
    parameter logic [31:0] ID_VAL  = 32'h0000_0051,
    parameter logic [31:0] VER_VAL = 32'h0000_0013
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               bus_we,
    input  logic [9:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq
);

    localparam int NUM_CTR  = NUM_EVT + 1;
    localparam int TIME_IDX = NUM_EVT;

    wr_sel_t                  wsel;
    logic                     run_q;
    logic [NUM_EVT-1:0]       cfg_q;
    logic [NUM_CTR-1:0]       wbits;
    logic [NUM_CTR-1:0]       ctr_inc;
    logic [NUM_CTR-1:0]       ctr_clr;
    logic [NUM_CTR*CNT_W-1:0] ctr_vals;
    logic [NUM_CTR-1:0]       ctr_ovf;
    logic [NUM_CTR-1:0]       ctr_wrap;
    logic [NUM_CTR-1:0]       ier_bits;
    logic [NUM_CTR-1:0]       isr_bits;
    logic [REG_W-1:0]         ovf_word;
    logic [REG_W-1:0]         ier_word;
    logic [REG_W-1:0]         isr_word;
    logic                     any_wrap;
    logic                     unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata;

    // write decode
    always_comb begin
        wsel      = '0;
        wsel.ctrl = bus_we && (bus_addr == OFS_CTRL);
        wsel.cfg  = bus_we && (bus_addr == OFS_CFG);
        wsel.clr  = bus_we && (bus_addr == OFS_CLR);
        wsel.ier  = bus_we && (bus_addr == OFS_IER);
        wsel.icr  = bus_we && (bus_addr == OFS_ICR);
    end

    // register-bit layout to counter index: event X at bit X, cycle counter at bit 31
    always_comb begin
        wbits    = '0;
        ovf_word = '0;
        ier_word = '0;
        isr_word = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            wbits[i]    = bus_wdata[i];
            ovf_word[i] = ctr_ovf[i];
            ier_word[i] = ier_bits[i];
            isr_word[i] = isr_bits[i];
        end
        wbits[TIME_IDX]    = bus_wdata[TIME_BIT];
        ovf_word[TIME_BIT] = ctr_ovf[TIME_IDX];
        ier_word[TIME_BIT] = ier_bits[TIME_IDX];
        isr_word[TIME_BIT] = isr_bits[TIME_IDX];
    end

    assign any_wrap = |ctr_wrap;

    // run control: overflow freezes, stop beats start
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else if (any_wrap) begin
            run_q <= 1'b0;
        end else if (wsel.ctrl && bus_wdata[CTRL_STOP_BIT]) begin
            run_q <= 1'b0;
        end else if (wsel.ctrl && bus_wdata[CTRL_START_BIT]) begin
            run_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wsel.cfg) begin
            cfg_q <= bus_wdata[NUM_EVT-1:0];
        end
    end

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_inc
        assign ctr_inc[g] = run_q & cfg_q[g] & evt_pulse[g];
    end
    assign ctr_inc[TIME_IDX] = run_q;
    assign ctr_clr           = wsel.clr ? wbits : '0;

    mc_evt_bank #(
        .NUM_CTR (NUM_CTR),
        .CNT_W   (CNT_W)
    ) bank_i (
        .clk  (clk),
        .rst  (rst),
        .inc  (ctr_inc),
        .clr  (ctr_clr),
        .vals (ctr_vals),
        .ovf  (ctr_ovf),
        .wrap (ctr_wrap)
    );

    mc_evt_irq #(
        .NUM_CTR (NUM_CTR)
    ) irq_i (
        .clk    (clk),
        .rst    (rst),
        .set    (ctr_wrap),
        .ier_we (wsel.ier),
        .icr_we (wsel.icr),
        .wbits  (wbits),
        .ier    (ier_bits),
        .isr    (isr_bits),
        .irq    (irq)
    );

    // read decode
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:  bus_rdata[0] = run_q;
            OFS_CFG:   bus_rdata[NUM_EVT-1:0] = cfg_q;
            OFS_STAT:  bus_rdata = ovf_word;
            OFS_IER:   bus_rdata = ier_word;
            OFS_ISR:   bus_rdata = isr_word;
            OFS_TIME:  bus_rdata = REG_W'(ctr_vals[TIME_IDX*CNT_W +: CNT_W]);
            OFS_HWCFG: bus_rdata = {16'h0000, 8'(CNT_W), 8'(NUM_EVT)};
            OFS_VER:   bus_rdata = VER_VAL;
            OFS_IDR:   bus_rdata = ID_VAL;
            OFS_SIG:   bus_rdata = SIG_VALUE;
            default:   bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_EVT; i++) begin
            if (bus_addr == evt_ofs(i)) begin
                bus_rdata = REG_W'(ctr_vals[i*CNT_W +: CNT_W]);
            end
        end
    end

    AST_FREEZE_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        any_wrap |=> !run_q); // R7

    AST_RESUME_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (wsel.ctrl && bus_wdata[CTRL_START_BIT] && !bus_wdata[CTRL_STOP_BIT] && !any_wrap)
        |=> run_q); // R8

    AST_STOPPED_TIME_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !wsel.clr) |=> $stable(ctr_vals)); // R2

endmodule

// File: tb/mc_evt_monitor_tb.sv
`timescale 1ns/1ps
module mc_evt_monitor_tb_top;
    import mc_evt_pkg::*;

    localparam int NE   = 4;
    localparam int NC   = NE + 1;
    localparam int CW   = 6;
    localparam int MAXV = (1 << CW) - 1;
    localparam logic [31:0] TB_ID  = 32'h0000_0077;
    localparam logic [31:0] TB_VER = 32'h0000_0102;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NE-1:0] evt_pulse = '0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    mc_evt_monitor #(
        .NUM_EVT (NE),
        .CNT_W   (CW),
        .ID_VAL  (TB_ID),
        .VER_VAL (TB_VER)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // requirement model
    int          m_cnt [NC];
    logic        m_run = 1'b0;
    logic [NE-1:0] m_cfg = '0;
    logic [NC-1:0] m_ovf = '0;
    logic [NC-1:0] m_isr = '0;
    logic [NC-1:0] m_ier = '0;

    function automatic logic [31:0] to_word(input logic [NC-1:0] v);
        logic [31:0] w = '0;
        for (int i = 0; i < NE; i++) w[i] = v[i];
        w[31] = v[NE];
        return w;
    endfunction

    function automatic logic [NC-1:0] from_word(input logic [31:0] w);
        logic [NC-1:0] v;
        for (int i = 0; i < NE; i++) v[i] = w[i];
        v[NE] = w[31];
        return v;
    endfunction

    task automatic model_step(input logic [NE-1:0] ev, input logic we,
                              input logic [9:0] addr, input logic [31:0] data);
        logic [NC-1:0] wr = '0;
        logic [NC-1:0] clr = '0;
        if (we && addr == OFS_CLR) clr = from_word(data);
        for (int i = 0; i < NC; i++) begin
            logic inc;
            inc = m_run && ((i == NE) || (m_cfg[i] && ev[i]));
            if (clr[i]) begin
                m_cnt[i] = 0;
                m_ovf[i] = 1'b0;
            end else if (inc) begin
                if (m_cnt[i] == MAXV) begin
                    m_cnt[i] = 0;
                    wr[i] = 1'b1;
                end else begin
                    m_cnt[i] = m_cnt[i] + 1;
                end
            end
        end
        m_ovf = m_ovf | wr;
        if (we && addr == OFS_ICR) m_isr = m_isr & ~from_word(data);
        m_isr = m_isr | wr;
        if (we && addr == OFS_IER) m_ier = from_word(data);
        if (we && addr == OFS_CFG) m_cfg = data[NE-1:0];
        if (|wr) m_run = 1'b0;
        else if (we && addr == OFS_CTRL && data[1]) m_run = 1'b0;
        else if (we && addr == OFS_CTRL && data[0]) m_run = 1'b1;
    endtask

    task automatic drive(input logic [NE-1:0] ev, input logic we,
                         input logic [9:0] addr, input logic [31:0] data);
        evt_pulse = ev;
        bus_we    = we;
        bus_addr  = addr;
        bus_wdata = data;
        @(posedge clk);
        model_step(ev, we, addr, data);
        @(negedge clk);
        evt_pulse = '0;
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic wr(input logic [9:0] addr, input logic [31:0] data);
        drive('0, 1'b1, addr, data);
    endtask

    task automatic cyc(input logic [NE-1:0] ev);
        drive(ev, 1'b0, 10'h000, 32'h0);
    endtask

    task automatic rd(input logic [9:0] addr, output logic [31:0] data);
        bus_addr = addr;
        #0.2;
        data = bus_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [9:0] addr, input logic [31:0] exp);
        logic [31:0] d;
        rd(addr, d);
        chk($sformatf("%s @%h", tag, addr), d, exp);
    endtask

    task automatic chk_ctrs(input string tag);
        for (int i = 0; i < NE; i++) chk_rd(tag, evt_ofs(i), 32'(m_cnt[i]));
        chk_rd(tag, OFS_TIME, 32'(m_cnt[NE]));
    endtask

    task automatic chk_all(input string tag);
        chk_ctrs(tag);
        chk_rd(tag, OFS_STAT, to_word(m_ovf));
        chk_rd(tag, OFS_CTRL, {31'b0, m_run});
        chk_rd(tag, OFS_ISR, to_word(m_isr));
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, |(m_isr & m_ier)});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) m_cnt[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_all("R1");
        chk_rd("R1 cfg", OFS_CFG, 32'h0);
        chk_rd("R1 ier", OFS_IER, 32'h0);

        // R10 fixed registers, writes ignored
        chk_rd("R10", OFS_SIG, 32'hA3C5_DD01);
        chk_rd("R10", OFS_IDR, TB_ID);
        chk_rd("R10", OFS_VER, TB_VER);
        chk_rd("R10", OFS_HWCFG, {16'h0, 8'(CW), 8'(NE)});
        wr(OFS_SIG, 32'h0);
        wr(OFS_IDR, 32'hFFFF_FFFF);
        wr(OFS_HWCFG, 32'h1234_5678);
        chk_rd("R10 after write", OFS_SIG, 32'hA3C5_DD01);
        chk_rd("R10 after write", OFS_IDR, TB_ID);
        chk_rd("R10 after write", OFS_HWCFG, {16'h0, 8'(CW), 8'(NE)});

        // R11 unmapped and write-only offsets
        chk_rd("R11", 10'h024, 32'h0);
        chk_rd("R11", 10'h1F0, 32'h0);
        chk_rd("R11", 10'h3EC, 32'h0);
        chk_rd("R11", OFS_CLR, 32'h0);
        chk_rd("R11", OFS_ICR, 32'h0);

        // R3 / R4 sweep over all enable masks
        for (int c = 0; c < 16; c++) begin
            wr(OFS_CLR, 32'h8000_000F);
            wr(OFS_CFG, 32'(c));
            wr(OFS_CTRL, 32'h1);
            for (int k = 0; k < 8; k++) cyc(4'((k * 5 + c) % 16));
            wr(OFS_CTRL, 32'h2);
            for (int i = 0; i < NE; i++) chk_rd("R3", evt_ofs(i), 32'(m_cnt[i]));
            chk_rd("R4", OFS_TIME, 32'(m_cnt[NE]));
        end

        // R2 hold while stopped, stop beats start
        wr(OFS_CFG, 32'hF);
        repeat (4) cyc(4'hF);
        chk_ctrs("R2 hold");
        wr(OFS_CTRL, 32'h3);
        chk_rd("R2 stop wins", OFS_CTRL, 32'h0);
        repeat (2) cyc(4'hF);
        chk_ctrs("R2 hold after both");

        // R5 selective and full clears
        wr(OFS_CTRL, 32'h1);
        repeat (10) cyc(4'hF);
        wr(OFS_CTRL, 32'h2);
        wr(OFS_CLR, 32'h1);
        chk_ctrs("R5 clear bit0");
        wr(OFS_CLR, 32'h8000_0000);
        chk_ctrs("R5 clear time");
        wr(OFS_CLR, 32'h8000_000F);
        chk_ctrs("R5 clear all");

        // R6 clear beats increment
        wr(OFS_CTRL, 32'h1);
        repeat (3) cyc(4'hF);
        drive(4'hF, 1'b1, OFS_CLR, 32'h4);
        wr(OFS_CTRL, 32'h2);
        chk_rd("R6", evt_ofs(2), 32'h0);
        chk_ctrs("R6");

        // R7 overflow of cycle counter; read counter lags
        wr(OFS_CLR, 32'h8000_000F);
        wr(OFS_CFG, 32'h1);
        wr(OFS_IER, 32'h1);
        wr(OFS_CTRL, 32'h1);
        repeat (3) cyc(4'h0);
        for (int g = 0; g < 200 && m_run; g++) cyc(4'h1);
        chk_all("R7 wrap");
        chk_rd("R7 status", OFS_STAT, 32'h8000_0000);
        repeat (3) cyc(4'h1);
        chk_all("R7 frozen");

        // R9 masking and clearing
        chk({"R9 masked"}, {31'b0, irq}, 32'h0);
        wr(OFS_IER, 32'h8000_0001);
        chk({"R9 enabled"}, {31'b0, irq}, 32'h1);
        wr(OFS_ICR, 32'h8000_0000);
        chk({"R9 cleared"}, {31'b0, irq}, 32'h0);
        chk_all("R9");

        // R8 resume after clear and start
        wr(OFS_CLR, 32'h8000_0000);
        chk_rd("R5 flag cleared", OFS_STAT, 32'h0);
        wr(OFS_CTRL, 32'h1);
        cyc(4'h1);
        wr(OFS_CTRL, 32'h2);
        chk_all("R8");

        // read counter overflow with interrupt enabled
        wr(OFS_CTRL, 32'h1);
        for (int g = 0; g < 200 && m_run; g++) cyc(4'h1);
        chk_all("R7 read wrap");
        chk({"R9 irq on"}, {31'b0, irq}, 32'h1);
        wr(OFS_ICR, 32'h1);
        chk_all("R9 icr");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule